// File: doc/BRIEF.md
# PCI Initiator Transaction Sequencer

This block acts as the bus master for single-word and burst read or write transactions on a 32-bit PCI bus. A local client hands it one request at a time: a bus command, a start address, an active-low byte-enable mask and a word count of at least one. The sequencer then runs the address phase, the data phases and a final turnaround cycle. It assumes bus ownership has already been granted. It does not generate or check parity, and it does not run configuration cycles.

While it is in the data phases, the sequencer watches the target's device-select, ready and stop lines. It inserts wait cycles until both sides are ready. When it sees no decode in time, it ends the transaction with a master abort. When the target asks it to stop, it tells apart retry, disconnect and target abort. Write data comes from a head-of-queue word that the client advances on every acknowledged transfer. Read data is handed back one cycle after each transfer. When the transaction closes, a single pulse reports an outcome code and the number of words that were not moved.

Top module: `pci_mstr_seq`

## Requirements
- R1: In the cycle after a request is accepted (req_valid high while req_ready high), the bus shows the address phase. frame_n_o is low, irdy_n_o is high and driven, ad_o carries the request address with ad_oe high, and cbe_n_o carries the request command.
- R2: In every data-phase cycle, cbe_n_o carries the request's active-low byte-enable mask. For a write (req_write=1), ad_o drives wr_data with ad_oe high. For a read, ad_oe is low.
- R3: A word moves only in a data-phase cycle where devsel_n_i and trdy_n_i are both low. xfer_ack is high in exactly those cycles. Read data sampled from ad_i appears on rd_data with rd_valid high in the next cycle.
- R4: irdy_n_o stays low throughout every data phase until the transaction ends. frame_n_o is low during data phases, except while the final remaining word is being transferred, when it is high.
- R5: If devsel_n_i stays high through the first 5 data-phase cycles, the transaction ends with outcome code 1 (master abort) and the full word count remaining.
- R6: Stop (stop_n_i low) with devsel_n_i low and trdy_n_i high, before any word has moved, ends the transaction with outcome code 2 (retry) and the full count remaining.
- R7: Stop with trdy_n_i low moves that word and ends with outcome code 3 (disconnect). Stop with trdy_n_i high after at least one word has moved also ends with code 3. In both cases the unmoved count is reported.
- R8: If devsel_n_i goes high again after the target was seen selected, the transaction ends with outcome code 4 (target abort) and the unmoved count.
- R9: When a transaction ends, there is one cycle with frame_n_o and irdy_n_o driven high and done_valid high, carrying done_status and done_remain. In the next cycle all bus outputs are released and req_ready is high.
- R10: A transaction in which every word moves, including one where stop comes together with the final word, ends with outcome code 0 and a remaining count of 0.
- R11: After reset, req_ready is high, and ctl_oe, ad_oe, done_valid, rd_valid and xfer_ack are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cmd | input | 4 | Bus command for the address phase |
| req_addr | input | 32 | Start address |
| req_be_n | input | 4 | Active-low byte enables for all data phases |
| req_count | input | CW | Number of words (at least 1) |
| wr_data | input | 32 | Current write word (queue head) |
| xfer_ack | output | 1 | A word moves at this clock edge |
| rd_data | output | 32 | Captured read word |
| rd_valid | output | 1 | rd_data holds a new word |
| done_valid | output | 1 | Transaction outcome pulse |
| done_status | output | 3 | 0 ok, 1 master abort, 2 retry, 3 disconnect, 4 target abort |
| done_remain | output | CW | Words not moved |
| ad_o | output | 32 | Address/data out |
| ad_oe | output | 1 | Address/data output enable |
| ad_i | input | 32 | Address/data in |
| cbe_n_o | output | 4 | Command / byte enables, active low |
| frame_n_o | output | 1 | Frame, active low |
| irdy_n_o | output | 1 | Initiator ready, active low |
| ctl_oe | output | 1 | Enable for frame, irdy and C/BE drivers |
| devsel_n_i | input | 1 | Target device select, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| stop_n_i | input | 1 | Target stop, active low |

## Verification
If the remaining-word counter drifts, the problem shows on frame_n_o: it rises one phase early or late, in the very data cycle concerned. It also shows in done_remain at the end of the transaction. If the decode timer is off by one, the master abort comes one cycle early or late, and a target that decodes in the fifth cycle gets aborted wrongly. A wrong response classification shows up directly as a wrong done_status in the turnaround cycle that follows the terminating edge. A lost turnaround or a stuck state leaves ctl_oe high, or keeps req_ready low, one cycle later.

// File: rtl/pci_seq_pkg.sv
package pci_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_TURN = 2'd3
    } seq_state_e;

    typedef enum logic [2:0] {
        END_OK     = 3'd0,
        END_MABORT = 3'd1,
        END_RETRY  = 3'd2,
        END_DISC   = 3'd3,
        END_TABORT = 3'd4
    } end_code_e;

endpackage

// File: rtl/pci_devsel_watch.sv
module pci_devsel_watch #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic devsel_n_i,
    output logic seen_o,
    output logic timeout_o
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST_SLOT = TW'(LIMIT - 1);

    logic [TW-1:0] cnt_d, cnt_q;
    logic          seen_d, seen_q;

    always_comb begin
        cnt_d  = cnt_q;
        seen_d = seen_q;
        if (!active_i) begin
            cnt_d  = '0;
            seen_d = 1'b0;
        end else begin
            if (!devsel_n_i) seen_d = 1'b1;
            if (!seen_q && cnt_q != LAST_SLOT) cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            seen_q <= seen_d;
        end
    end

    assign seen_o    = seen_q;
    assign timeout_o = active_i && devsel_n_i && !seen_q && (cnt_q == LAST_SLOT);

    // R5: the window counter never passes its final slot
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_SLOT);

    // R5: a timeout cannot fire once the target has answered
    assert_no_late_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !devsel_n_i) |=> !timeout_o);

endmodule

// File: rtl/pci_term_decode.sv
module pci_term_decode
    import pci_seq_pkg::*;
(
    input  logic      active_i,
    input  logic      devsel_n_i,
    input  logic      trdy_n_i,
    input  logic      stop_n_i,
    input  logic      seen_i,
    input  logic      timeout_i,
    input  logic      last_i,
    input  logic      moved_any_i,
    output logic      xfer_o,
    output logic      finish_o,
    output end_code_e code_o
);
    always_comb begin
        xfer_o   = 1'b0;
        finish_o = 1'b0;
        code_o   = END_OK;
        if (active_i) begin
            if (devsel_n_i) begin
                if (seen_i) begin
                    finish_o = 1'b1;
                    code_o   = END_TABORT;
                end else if (timeout_i) begin
                    finish_o = 1'b1;
                    code_o   = END_MABORT;
                end
            end else if (!trdy_n_i) begin
                xfer_o = 1'b1;
                if (last_i) begin
                    finish_o = 1'b1;
                    code_o   = END_OK;
                end else if (!stop_n_i) begin
                    finish_o = 1'b1;
                    code_o   = END_DISC;
                end
            end else if (!stop_n_i) begin
                finish_o = 1'b1;
                code_o   = moved_any_i ? END_DISC : END_RETRY;
            end
        end
    end
endmodule

// File: rtl/pci_mstr_seq.sv
module pci_mstr_seq
    import pci_seq_pkg::*;
#(
    parameter int DW           = 32,
    parameter int CW           = 8,
    parameter int DEVSEL_LIMIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [3:0]    req_cmd,
    input  logic [DW-1:0] req_addr,
    input  logic [3:0]    req_be_n,
    input  logic [CW-1:0] req_count,
    input  logic [DW-1:0] wr_data,
    output logic          xfer_ack,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          done_valid,
    output logic [2:0]    done_status,
    output logic [CW-1:0] done_remain,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe,
    input  logic [DW-1:0] ad_i,
    output logic [3:0]    cbe_n_o,
    output logic          frame_n_o,
    output logic          irdy_n_o,
    output logic          ctl_oe,
    input  logic          devsel_n_i,
    input  logic          trdy_n_i,
    input  logic          stop_n_i
);
    localparam logic [CW-1:0] ONE_WORD = CW'(1);

    typedef struct packed {
        seq_state_e    st;
        logic [3:0]    cmd;
        logic [DW-1:0] addr;
        logic [3:0]    be_n;
        logic          wr;
        logic [CW-1:0] remain;
        logic          moved;
        end_code_e     code;
        logic [DW-1:0] rdat;
        logic          rvld;
    } seq_regs_t;

    seq_regs_t q, d;

    logic      in_data;
    logic      last_word;
    logic      seen;
    logic      timeout;
    logic      xfer;
    logic      finish;
    end_code_e code;

    assign in_data   = (q.st == ST_DATA);
    assign last_word = (q.remain == ONE_WORD);

    pci_devsel_watch #(.LIMIT(DEVSEL_LIMIT)) u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (in_data),
        .devsel_n_i (devsel_n_i),
        .seen_o     (seen),
        .timeout_o  (timeout)
    );

    pci_term_decode u_decode (
        .active_i    (in_data),
        .devsel_n_i  (devsel_n_i),
        .trdy_n_i    (trdy_n_i),
        .stop_n_i    (stop_n_i),
        .seen_i      (seen),
        .timeout_i   (timeout),
        .last_i      (last_word),
        .moved_any_i (q.moved),
        .xfer_o      (xfer),
        .finish_o    (finish),
        .code_o      (code)
    );

    always_comb begin
        d      = q;
        d.rvld = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st     = ST_ADDR;
                    d.cmd    = req_cmd;
                    d.addr   = req_addr;
                    d.be_n   = req_be_n;
                    d.wr     = req_write;
                    d.remain = req_count;
                    d.moved  = 1'b0;
                    d.code   = END_OK;
                end
            end
            ST_ADDR: d.st = ST_DATA;
            ST_DATA: begin
                if (xfer) begin
                    d.remain = q.remain - 1'b1;
                    d.moved  = 1'b1;
                    if (!q.wr) begin
                        d.rdat = ad_i;
                        d.rvld = 1'b1;
                    end
                end
                if (finish) begin
                    d.st   = ST_TURN;
                    d.code = code;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cmd: '0, addr: '0, be_n: '1, wr: 1'b0,
                   remain: '0, moved: 1'b0, code: END_OK, rdat: '0, rvld: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.st == ST_IDLE);
    assign ctl_oe      = (q.st != ST_IDLE);
    assign frame_n_o   = !((q.st == ST_ADDR) || (in_data && !last_word));
    assign irdy_n_o    = !in_data;
    assign cbe_n_o     = (q.st == ST_ADDR) ? q.cmd : q.be_n;
    assign ad_oe       = (q.st == ST_ADDR) || (in_data && q.wr);
    assign ad_o        = (q.st == ST_ADDR) ? q.addr : wr_data;
    assign xfer_ack    = xfer;
    assign rd_data     = q.rdat;
    assign rd_valid    = q.rvld;
    assign done_valid  = (q.st == ST_TURN);
    assign done_status = q.code;
    assign done_remain = q.remain;

    // R1: accepted request appears as the address phase one cycle later
    assert_addr_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!frame_n_o && irdy_n_o && ad_oe &&
            ad_o == $past(req_addr) && cbe_n_o == $past(req_cmd)));

    // R4: an unfinished data phase keeps the initiator ready asserted
    assert_irdy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !finish) |=> !irdy_n_o);

    // R3: each moved word lowers the remaining count by exactly one
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && xfer) |=> (done_remain == $past(done_remain) - 1'b1));

    // R3: read data is reported only after a moved word
    assert_rd_after_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(xfer));

    // R9: the turnaround cycle is followed by a released, idle bus
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!ctl_oe && !ad_oe && req_ready));

    // R4: once frame is raised in a data phase it stays raised
    assert_frame_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && frame_n_o) |=> frame_n_o);

endmodule

// File: tb/pci_mstr_seq_tb.sv
module pci_mstr_seq_tb;
    import pci_seq_pkg::*;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [3:0]    req_cmd = '0;
    logic [31:0]   req_addr = '0;
    logic [3:0]    req_be_n = '1;
    logic [CW-1:0] req_count = '0;
    logic [31:0]   wr_data = '0;
    logic          xfer_ack;
    logic [31:0]   rd_data;
    logic          rd_valid;
    logic          done_valid;
    logic [2:0]    done_status;
    logic [CW-1:0] done_remain;
    logic [31:0]   ad_o;
    logic          ad_oe;
    logic [31:0]   ad_i = '0;
    logic [3:0]    cbe_n_o;
    logic          frame_n_o;
    logic          irdy_n_o;
    logic          ctl_oe;
    logic          devsel_n_i = 1'b1;
    logic          trdy_n_i = 1'b1;
    logic          stop_n_i = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pci_mstr_seq #(.DW(32), .CW(CW), .DEVSEL_LIMIT(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_be_n(req_be_n), .req_count(req_count), .wr_data(wr_data),
        .xfer_ack(xfer_ack), .rd_data(rd_data), .rd_valid(rd_valid),
        .done_valid(done_valid), .done_status(done_status), .done_remain(done_remain),
        .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .cbe_n_o(cbe_n_o),
        .frame_n_o(frame_n_o), .irdy_n_o(irdy_n_o), .ctl_oe(ctl_oe),
        .devsel_n_i(devsel_n_i), .trdy_n_i(trdy_n_i), .stop_n_i(stop_n_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] wdat(input int idx);
        return 32'hA5C3_0000 ^ (idx * 32'h0101_0107);
    endfunction

    function automatic logic [31:0] rdat(input int idx);
        return 32'h3C5A_9000 + (idx * 32'h0011_0203);
    endfunction

    function automatic string code_tag(input int code);
        case (code)
            0: return "R10 ok";
            1: return "R5 master abort";
            2: return "R6 retry";
            3: return "R7 disconnect";
            default: return "R8 target abort";
        endcase
    endfunction

    // Outcome expected from the requirements for one target scenario
    function automatic void predict(input int cnt, input int dly, input int sidx,
                                    input int smode, input int tidx,
                                    output int code, output int rem);
        code = 0;
        rem  = 0;
        if (dly >= 5) begin
            code = 1; rem = cnt; return;
        end
        for (int k = 0; k < cnt; k++) begin
            if (tidx == k) begin
                code = 4; rem = cnt - k; return;
            end
            if (sidx == k) begin
                if (smode == 0) begin
                    if (k == cnt - 1) begin code = 0; rem = 0; end
                    else begin code = 3; rem = cnt - k - 1; end
                end else begin
                    if (k == 0) begin code = 2; rem = cnt; end
                    else begin code = 3; rem = cnt - k; end
                end
                return;
            end
        end
    endfunction

    task automatic drive_tgt(input logic dv, input logic tr, input logic sp);
        devsel_n_i = dv;
        trdy_n_i   = tr;
        stop_n_i   = sp;
    endtask

    task automatic run_txn(input bit wr, input int cnt, input int dly, input int ws,
                           input int sidx, input int smode, input int tidx);
        int pcode, prem;
        int moved = 0;
        int c = 0;
        int ph_wait = 0;
        bit dev_prev = 1'b0;
        bit ended = 1'b0;
        bit pend = 1'b0;
        logic [31:0] pend_val = '0;
        logic [3:0]  cmd  = wr ? 4'h7 : 4'h6;
        logic [3:0]  be   = 4'($urandom);
        logic [31:0] addr = $urandom;
        predict(cnt, dly, sidx, smode, tidx, pcode, prem);

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_cmd = cmd; req_addr = addr;
        req_be_n = be; req_count = CW'(cnt);
        chk(req_ready, "R9 ready before request", 64'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!frame_n_o && irdy_n_o && ctl_oe && ad_oe && ad_o == addr && cbe_n_o == cmd,
            "R1 address phase", {frame_n_o, irdy_n_o, cbe_n_o, ad_o}, {2'b01, cmd, addr});

        while (!ended && c < 64) begin
            bit x = 1'b0;
            bit dev_on;
            @(negedge clk);
            if (pend) begin
                chk(rd_valid && rd_data == pend_val, "R3 read data", {rd_valid, rd_data},
                    {1'b1, pend_val});
                pend = 1'b0;
            end
            chk(!irdy_n_o && ctl_oe, "R4 irdy in data phase", 64'(irdy_n_o), 0);
            chk(frame_n_o == ((cnt - moved) == 1), "R4 frame vs last word",
                64'(frame_n_o), 64'((cnt - moved) == 1));
            chk(cbe_n_o == be, "R2 byte enables", 64'(cbe_n_o), 64'(be));
            wr_data = wdat(moved);
            ad_i    = rdat(moved);
            dev_on  = (c >= dly);
            if (!dev_on) begin
                drive_tgt(1, 1, 1);
                if (c == 4) ended = 1'b1;
            end else if (tidx == moved) begin
                if (dev_prev) begin drive_tgt(1, 1, 0); ended = 1'b1; end
                else drive_tgt(0, 1, 1);
            end else if (ph_wait < ws) begin
                drive_tgt(0, 1, 1);
                ph_wait++;
            end else if (sidx == moved) begin
                if (smode == 0) begin drive_tgt(0, 0, 0); x = 1'b1; end
                else drive_tgt(0, 1, 0);
                ended = 1'b1;
            end else begin
                drive_tgt(0, 0, 1);
                x = 1'b1;
                if (moved == cnt - 1) ended = 1'b1;
            end
            dev_prev = dev_on;
            #1;
            chk(xfer_ack == x, "R3 transfer ack", 64'(xfer_ack), 64'(x));
            if (wr) chk(ad_oe && ad_o == wdat(moved), "R2 write data", {ad_oe, ad_o},
                        {1'b1, wdat(moved)});
            else chk(!ad_oe, "R2 read releases AD", 64'(ad_oe), 0);
            if (x) begin
                if (!wr) begin pend = 1'b1; pend_val = rdat(moved); end
                moved++;
                ph_wait = 0;
            end
            c++;
        end

        @(negedge clk);
        drive_tgt(1, 1, 1);
        if (pend) chk(rd_valid && rd_data == pend_val, "R3 read data last",
                      {rd_valid, rd_data}, {1'b1, pend_val});
        chk(done_valid && frame_n_o && irdy_n_o && ctl_oe, "R9 turnaround cycle",
            {done_valid, frame_n_o, irdy_n_o, ctl_oe}, 4'hF);
        chk(done_status == 3'(pcode), code_tag(pcode), 64'(done_status), 64'(pcode));
        chk(done_remain == CW'(prem), code_tag(pcode), 64'(done_remain), 64'(prem));
        @(negedge clk);
        chk(!ctl_oe && !ad_oe && req_ready && !done_valid, "R9 bus released",
            {ctl_oe, ad_oe, req_ready, done_valid}, 4'b0010);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd24681));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !ctl_oe && !ad_oe && !done_valid && !rd_valid && !xfer_ack,
            "R11 reset state", {req_ready, ctl_oe, ad_oe, done_valid, rd_valid, xfer_ack},
            6'b100000);

        // directed corners
        run_txn(1, 4, 1, 0, 99, 0, 99);   // R10 write burst
        run_txn(0, 1, 2, 1, 99, 0, 99);   // R10 single read with wait
        run_txn(0, 3, 5, 0, 99, 0, 99);   // R5 no decode in window
        run_txn(1, 2, 4, 0, 99, 0, 99);   // R5 decode in last allowed cycle
        run_txn(0, 3, 1, 1, 0, 1, 99);    // R6 retry
        run_txn(1, 4, 0, 0, 1, 0, 99);    // R7 disconnect with data
        run_txn(0, 3, 2, 0, 2, 0, 99);    // R10 stop with final word
        run_txn(1, 5, 1, 2, 2, 1, 99);    // R7 disconnect without data
        run_txn(0, 2, 0, 0, 99, 0, 0);    // R8 target abort before data
        run_txn(1, 6, 3, 1, 99, 0, 2);    // R8 target abort mid burst

        for (int i = 0; i < 40; i++) begin
            int cnt = 1 + int'($urandom % 8);
            run_txn(1'($urandom), cnt, int'($urandom % 7), int'($urandom % 3),
                    int'($urandom % (cnt + 2)), int'($urandom % 2),
                    int'($urandom % (cnt + 3)));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule